// File: doc/BRIEF.md
# Tamper Pin Detector

This block watches six tamper inputs and reports intrusion attempts. Software chooses between two arrangements. In the first, each input is an independent detector that fires when its filtered value moves into a chosen active level. In the second, the inputs are grouped into three drive/sense loops. The block drives a known level out on each loop and flags the loop when the level that comes back disagrees with it.

Every input goes through a synchronizer and a debounce filter before any decision is made. A detection on an enabled channel does two things. It sets a sticky status flag, which drives the interrupt. It also starts a hardware wipe of the 80-byte backup store, written as twenty 32-bit zero words, one word per clock. A small two-register port holds the configuration and the status. Status flags are cleared by writing a 1 to them.

Top module: `tamper_guard`

## Requirements
- R1: Each input is synchronized by two flops and then accepted only after three consecutive equal samples. A pulse that lasts two clock cycles never reaches detection. A pulse that lasts three cycles does.
- R2: Single-pin mode applies when control bit 12 is 0. Channel i raises its event when its filtered input changes to the active level in control bit 6+i (1 = high, 0 = low). The event sets status bit i. A change to the inactive level raises nothing.
- R3: Loop mode applies when control bit 12 is 1. Output loop_drv_o[k] carries control bit 6+k, and tamper_i[2k+1] is the sensed pin. When the filtered sensed pin goes from matching the driven level to differing from it, status bit k is set. tamper_i[2k] has no effect in this mode. Outside loop mode, loop_drv_o is all zero.
- R4: A channel sets no flag and starts no wipe unless its enable bit, control bit i, is 1.
- R5: The status register is at address 1. Flags in bits 5:0 stay set until a 1 is written to that bit. Bit 6 reads 1 while a wipe is in progress.
- R6: irq_o is high exactly while some status flag is set and its enable bit is also set.
- R7: A detection starts a wipe. The wipe is 20 consecutive write strobes, one per cycle, to addresses 0 through 19, with zero data.
- R8: A detection during a wipe restarts the address sequence at 0. The wipe then runs 20 more strobes after that detection.
- R9: After reset, both registers read 0, irq_o is low, no wipe strobe is issued and loop_drv_o is 0.
- R10: The control register is at address 0. It reads back what was written: enables in bits 5:0, levels in bits 11:6 and the mode in bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tamper_i | input | 6 | Asynchronous tamper inputs |
| loop_drv_o | output | 3 | Drive level for each loop in loop mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 13 | Register write data |
| reg_rdata_o | output | 13 | Register read data (combinational) |
| irq_o | output | 1 | Tamper interrupt |
| wipe_we_o | output | 1 | Backup store write strobe |
| wipe_addr_o | output | 5 | Backup store word address |
| wipe_data_o | output | 32 | Backup store write data (always zero) |

## Verification
The bench builds the block with its default parameters: six pins, two synchronizer stages, a three-sample filter and a 20-word wipe. These values are small enough to sweep every channel at both active levels in single-pin mode, and every loop at both drive levels. Each case counts the whole wipe strobe sequence. The same small filter depth brings the two- and three-cycle pulse boundary within reach. The short wipe makes it practical to hit a restart in the middle of a wipe and to count the exact 25-strobe total.

// File: rtl/tamper_guard_pkg.sv
package tamper_guard_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tamper_guard_filter.sv
module tamper_guard_filter #(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [SYNC_STAGES-1:0]  sync_q;
  logic [DEBOUNCE_LEN-1:0] hist_q;
  logic                    level_q;
  logic                    agree;

  assign agree = (&hist_q) || (~|hist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      hist_q  <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q <= {hist_q[DEBOUNCE_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (agree) level_q <= hist_q[0];
    end
  end

  assign level_o = level_q;

  // filtered level only moves after a full run of equal samples
  assert_filter_agree_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> $past(agree));
endmodule

// File: rtl/tamper_guard_detect.sv
module tamper_guard_detect #(
  parameter int NUM_PINS = 6,
  localparam int PAIRS = NUM_PINS / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic                loop_i,
  output logic [NUM_PINS-1:0] event_o,
  output logic [PAIRS-1:0]    drive_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [NUM_PINS-1:0] prev_q;
  logic [PAIRS-1:0]    miss, miss_q;
  logic [NUM_PINS-1:0] single_hit, loop_vec;

  for (genvar k = 0; k < PAIRS; k++) begin : g_loop
    assign drive_o[k] = loop_i & lvl_i[k];
    assign miss[k]    = level_i[2*k+1] ^ lvl_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      miss_q <= '0;
    end else begin
      prev_q <= level_i;
      miss_q <= miss;
    end
  end

  // entry into the active level only
  assign single_hit = (level_i ^ prev_q) & ~(level_i ^ lvl_i);

  always_comb begin
    loop_vec = '0;
    loop_vec[PAIRS-1:0] = miss & ~miss_q;
  end

  assign event_o = en_i & (loop_i ? loop_vec : single_hit);
endmodule

// File: rtl/tamper_guard_wipe.sv
module tamper_guard_wipe #(
  parameter int WIPE_WORDS = 20,
  parameter int DATA_W     = 32,
  localparam int AW = $clog2(WIPE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] data_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [AW-1:0] LAST = AW'(WIPE_WORDS - 1);

  logic          busy_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q;
  assign addr_o = cnt_q;
  assign data_o = '0;

  assert_wipe_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && cnt_q == '0));
  assert_wipe_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  assert_wipe_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_guard_pkg::*;
#(
  parameter int NUM_PINS     = 6,
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE_LEN = 3,
  parameter int WIPE_WORDS   = 20,
  parameter int DATA_W       = 32,
  localparam int PAIRS   = NUM_PINS / 2,
  localparam int REG_W   = 2 * NUM_PINS + 1,
  localparam int WIPE_AW = $clog2(WIPE_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] tamper_i,
  output logic [PAIRS-1:0]    loop_drv_o,
  input  logic                reg_we_i,
  input  logic                reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                irq_o,
  output logic                wipe_we_o,
  output logic [WIPE_AW-1:0]  wipe_addr_o,
  output logic [DATA_W-1:0]   wipe_data_o
);
  timeunit 1ns; timeprecision 1ps;

  // control layout: enables [N-1:0], levels [2N-1:N], mode [2N]
  localparam int LVL_LSB  = NUM_PINS;
  localparam int LOOP_BIT = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] level, events;
  logic [NUM_PINS-1:0] en_q, lvl_q, flags_q, clr_mask, keep;
  logic                loop_q, busy;
  logic                ctrl_wr, stat_wr;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    tamper_guard_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEBOUNCE_LEN(DEBOUNCE_LEN)
    ) u_filter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (tamper_i[i]),
      .level_o(level[i])
    );
  end

  tamper_guard_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level),
    .en_i   (en_q),
    .lvl_i  (lvl_q),
    .loop_i (loop_q),
    .event_o(events),
    .drive_o(loop_drv_o)
  );

  tamper_guard_wipe #(.WIPE_WORDS(WIPE_WORDS), .DATA_W(DATA_W)) u_wipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(|events),
    .busy_o (busy),
    .we_o   (wipe_we_o),
    .addr_o (wipe_addr_o),
    .data_o (wipe_data_o)
  );

  assign ctrl_wr  = reg_we_i && (reg_addr_i == SEL_CTRL);
  assign stat_wr  = reg_we_i && (reg_addr_i == SEL_STAT);
  assign clr_mask = stat_wr ? reg_wdata_i[NUM_PINS-1:0] : '0;
  assign keep     = flags_q & ~clr_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      lvl_q   <= '0;
      loop_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= reg_wdata_i[NUM_PINS-1:0];
        lvl_q  <= reg_wdata_i[LVL_LSB +: NUM_PINS];
        loop_q <= reg_wdata_i[LOOP_BIT];
      end
      // a same-cycle detection wins over the clear
      flags_q <= keep | events;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == SEL_CTRL) begin
      reg_rdata_o[NUM_PINS-1:0]         = en_q;
      reg_rdata_o[LVL_LSB +: NUM_PINS]  = lvl_q;
      reg_rdata_o[LOOP_BIT]             = loop_q;
    end else begin
      reg_rdata_o[NUM_PINS-1:0] = flags_q;
      reg_rdata_o[NUM_PINS]     = busy;
    end
  end

  assign irq_o = |(flags_q & en_q);

  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & $past(keep)) == $past(keep)));
  assert_flag_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((flags_q & ~$past(flags_q)) & ~$past(en_q)) == '0));
endmodule

// File: tb/tamper_guard_test.sv
module tamper_guard_test;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  pins = '0;
  logic [2:0]  loop_drv;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [12:0] reg_wdata = '0;
  logic [12:0] reg_rdata;
  logic        irq, wipe_we;
  logic [4:0]  wipe_addr;
  logic [31:0] wipe_data;

  int checks = 0, fails = 0;
  int mon_cnt = 0, mon_bad = 0;
  logic [4:0] mon_last = '0;
  bit done = 0;

  always #5 clk = ~clk;

  tamper_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .tamper_i(pins), .loop_drv_o(loop_drv),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .wipe_we_o(wipe_we),
    .wipe_addr_o(wipe_addr), .wipe_data_o(wipe_data)
  );

  // wipe strobe monitor
  always begin
    @(negedge clk);
    #1;
    if (wipe_we) begin
      if (wipe_data != 32'd0) mon_bad++;
      if (mon_cnt == 0) begin
        if (wipe_addr != 5'd0) mon_bad++;
      end else if (wipe_addr != mon_last + 5'd1 && wipe_addr != 5'd0) mon_bad++;
      mon_last = wipe_addr;
      mon_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [12:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [12:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mon_clear();
    mon_cnt = 0; mon_bad = 0; mon_last = '0;
  endtask

  function automatic logic [12:0] ctrl(input logic [5:0] en, input logic [5:0] lvl, input logic loop);
    return {loop, lvl, en};
  endfunction

  task automatic check_wipe(input string req, input int cnt);
    check({req, " wipe strobes"}, mon_cnt, cnt);
    check({req, " wipe final addr"}, mon_last, 5'd19);
    check({req, " wipe seq/data"}, mon_bad, 0);
  endtask

  task automatic single_case(input int ch, input logic lvl);
    logic [12:0] d;
    wr(1'b0, 13'd0);
    pins = {6{~lvl}};
    tick(12);
    wr(1'b0, ctrl(6'(1 << ch), {6{lvl}}, 1'b0));
    wr(1'b1, 13'h3f);
    tick(30);
    mon_clear();
    check("R3 drive idle", loop_drv, 3'd0);
    pins[ch] = lvl;
    tick(15);
    rd(1'b1, d);
    check("R5 busy bit", d[6], 1'b1);
    tick(25);
    rd(1'b1, d);
    check("R2 flag", d, 13'(1 << ch));
    check("R6 irq set", irq, 1'b1);
    check_wipe("R7", 20);
    wr(1'b1, 13'(1 << ch));
    rd(1'b1, d);
    check("R5 w1c", d, 13'd0);
    check("R6 irq clear", irq, 1'b0);
    pins[ch] = ~lvl;
    tick(15);
    rd(1'b1, d);
    check("R2 inactive edge", d, 13'd0);
  endtask

  task automatic loop_case(input int k, input logic lvl);
    logic [12:0] d;
    wr(1'b0, 13'd0);
    pins = '0;
    pins[2*k+1] = lvl;
    tick(12);
    wr(1'b0, ctrl(6'(1 << k), {6{lvl}}, 1'b1));
    wr(1'b1, 13'h3f);
    tick(30);
    mon_clear();
    check("R3 drive", loop_drv, {3{lvl}});
    rd(1'b1, d);
    check("R3 match", d, 13'd0);
    pins[2*k] = ~pins[2*k];
    tick(15);
    rd(1'b1, d);
    check("R3 drive pin ignored", d, 13'd0);
    check("R3 drive pin no wipe", mon_cnt, 0);
    pins[2*k+1] = ~lvl;
    tick(40);
    rd(1'b1, d);
    check("R3 mismatch flag", d, 13'(1 << k));
    check("R6 loop irq", irq, 1'b1);
    check_wipe("R7 loop", 20);
    wr(1'b1, 13'h3f);
    tick(5);
    rd(1'b1, d);
    check("R3 cleared stays clear", d, 13'd0);
  endtask

  initial begin
    logic [12:0] d;
    tick(3);
    rst_n = 1'b1;
    // R9 reset state
    rd(1'b0, d); check("R9 ctrl", d, 13'd0);
    rd(1'b1, d); check("R9 status", d, 13'd0);
    check("R9 irq", irq, 1'b0);
    check("R9 wipe", wipe_we, 1'b0);
    check("R9 drive", loop_drv, 3'd0);

    // R10 readback
    wr(1'b0, 13'h1a5c);
    rd(1'b0, d); check("R10 readback", d, 13'h1a5c);

    for (int lv = 1; lv >= 0; lv--)
      for (int ch = 0; ch < 6; ch++) single_case(ch, 1'(lv));

    for (int lv = 0; lv < 2; lv++)
      for (int k = 0; k < 3; k++) loop_case(k, 1'(lv));

    // R4 disabled channel
    for (int ch = 0; ch < 6; ch++) begin
      wr(1'b0, 13'd0);
      pins = '0;
      tick(12);
      wr(1'b0, ctrl(~6'(1 << ch), 6'h3f, 1'b0));
      wr(1'b1, 13'h3f);
      tick(30);
      mon_clear();
      pins[ch] = 1'b1;
      tick(40);
      rd(1'b1, d);
      check("R4 disabled flag", d, 13'd0);
      check("R4 disabled wipe", mon_cnt, 0);
      check("R4 disabled irq", irq, 1'b0);
    end

    // R1 glitch boundary
    for (int ch = 0; ch < 6; ch++) begin
      wr(1'b0, 13'd0);
      pins = '0;
      tick(12);
      wr(1'b0, ctrl(6'(1 << ch), 6'h3f, 1'b0));
      wr(1'b1, 13'h3f);
      tick(30);
      mon_clear();
      pins[ch] = 1'b1; tick(2); pins[ch] = 1'b0;
      tick(30);
      rd(1'b1, d);
      check("R1 two-cycle pulse", d, 13'd0);
      check("R1 two-cycle no wipe", mon_cnt, 0);
      pins[ch] = 1'b1; tick(3); pins[ch] = 1'b0;
      tick(30);
      rd(1'b1, d);
      check("R1 three-cycle pulse", d, 13'(1 << ch));
    end

    // R6 irq masked by enable while flag remains
    wr(1'b0, 13'd0);
    rd(1'b1, d);
    check("R6 flag kept", d[5:0], 6'h20);
    check("R6 irq masked", irq, 1'b0);

    // R8 restart during wipe
    pins = '0;
    tick(12);
    wr(1'b0, ctrl(6'h03, 6'h3f, 1'b0));
    wr(1'b1, 13'h3f);
    tick(30);
    mon_clear();
    pins[0] = 1'b1;
    tick(5);
    pins[1] = 1'b1;
    tick(50);
    check_wipe("R8 restart", 25);
    rd(1'b1, d);
    check("R8 both flags", d, 13'h003);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule